// File: doc/BRIEF.md
# Virtual Segment Mapper With Fault Capture

This block turns a 32-bit virtual address into a physical address for one access per clock. It first sorts the address into one of five segments using the top three bits. Two kernel windows have a fixed offset translation and give read and write permission. The user window and the two upper kernel windows are translated through an external page-table lookup, which returns hit, valid, dirty and a page frame number in the same cycle. The block checks those flags and builds the physical address from the frame and the page offset. A user-mode access to any address with bit 31 set is stopped with an address error before any translation is tried.

When an access faults, the block reports a 5-bit exception code, a fault strobe and a refill flag. On that same clock edge it loads three capture registers: a bad-address register, and the upper 20 bits of a context register and an entry-high register. The results are registered, so they appear one cycle after the request. The capture registers can be read back all the time.

Top module: `vseg_mapper`

## Requirements
- R1: A user-mode access (user_mode=1) to an address at or above 0x80000000 faults with code 4 on a read and code 5 on a write. The refill flag is 0, both permissions are 0 and phys_addr is 0.
- R2: An address below 0x80000000 with err_level=1 and no R1 fault passes through unchanged, with read and write permission. No lookup is requested.
- R3: An address from 0x80000000 to 0x9FFFFFFF translates to the address minus 0x80000000, with read and write permission and no lookup.
- R4: An address from 0xA0000000 to 0xBFFFFFFF translates to the address minus 0xA0000000, with read and write permission and no lookup.
- R5: Two kinds of address are mapped: an address below 0x80000000 with err_level=0, and any address at or above 0xC0000000. For these, tlb_lookup is 1 in the request cycle. On a valid hit with no fault, phys_addr = {tlb_pfn, addr[11:0]}, perm_rd=1 and perm_wr=tlb_dirty.
- R6: A mapped access with tlb_hit=0 faults with code 2 on a read and code 3 on a write, with refill=1.
- R7: A mapped access that hits with tlb_valid=0 faults with code 2 on a read and code 3 on a write, with refill=0.
- R8: A mapped write that hits a valid entry with tlb_dirty=0 faults with code 1 and refill=0.
- R9: On every fault, rb_badvaddr takes the full address. rb_context and rb_entryhi take addr[31:12] in bits 31:12 and keep their own bits 11:0. These registers are visible in the same cycle that fault=1 appears.
- R10: Results appear one cycle after a request with resp_valid=1. With req_valid=0 the next cycle shows resp_valid=0 and all other result outputs 0. The capture registers change only on a fault.
- R11: After reset, resp_valid and fault are 0 and rb_badvaddr is 0. rb_context and rb_entryhi hold the CTX_RST and EHI_RST parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| user_mode | input | 1 | Access made in user mode |
| err_level | input | 1 | Error level active (low window bypass) |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_valid | input | 1 | Matching entry is valid |
| tlb_dirty | input | 1 | Matching entry is writable |
| tlb_pfn | input | 20 | Page frame number of the entry |
| tlb_lookup | output | 1 | Request needs the page-table lookup (combinational) |
| resp_valid | output | 1 | Registered result valid |
| phys_addr | output | 32 | Translated address |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| fault | output | 1 | Access faulted |
| exc_code | output | 5 | Exception code (0 when no fault) |
| exc_refill | output | 1 | Fault was a lookup miss |
| rb_badvaddr | output | 32 | Captured faulting address |
| rb_context | output | 32 | Context register |
| rb_entryhi | output | 32 | Entry-high register |

## Verification
The bench probes the exact segment edges 0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xBFFFFFFC and 0xC0000000. A wrong comparison at any of them would either send the access down the wrong translation or raise a spurious lookup. It tests the priority between user-mode protection and err_level: a design that let the error-level bypass win would return a pass-through address where an address error is due. It tests miss, invalid and non-dirty writes on both reads and writes, which would expose swapped load/store codes or a wrong refill flag. It checks that the low 12 bits of the context and entry-high registers survive a fault, and that the capture registers do not move on a good access or an idle cycle, which a design capturing on every request would fail.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int CODE_W = 5;

  typedef enum logic [2:0] {
    SEG_USER, SEG_KDIRECT, SEG_KUNCACHED, SEG_KMAP_LO, SEG_KMAP_HI
  } seg_e;

  localparam logic [CODE_W-1:0] EXC_NONE = 5'd0;
  localparam logic [CODE_W-1:0] EXC_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] EXC_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] EXC_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] EXC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] EXC_ADES = 5'd5;

  typedef struct packed {
    logic              valid;
    logic              fault;
    logic [CODE_W-1:0] code;
    logic              refill;
    logic              rd;
    logic              wr;
    logic [VA_W-1:0]   pa;
  } xlate_t;
endpackage

// File: rtl/vsm_seg_decode.sv
module vsm_seg_decode
  import vsm_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic            user,
  input  logic            erl,
  output seg_e            seg,
  output logic            mapped,
  output logic            addr_err,
  output logic [VA_W-1:0] fixed_pa
);
  localparam logic [VA_W-1:0] KDIRECT_BASE   = 32'h8000_0000;
  localparam logic [VA_W-1:0] KUNCACHED_BASE = 32'hA000_0000;

  always_comb begin
    unique casez (va[VA_W-1 -: 3])
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KDIRECT;
      3'b101:  seg = SEG_KUNCACHED;
      3'b110:  seg = SEG_KMAP_LO;
      default: seg = SEG_KMAP_HI;
    endcase
  end

  assign addr_err = user && va[VA_W-1];
  assign mapped   = ((seg == SEG_USER) && !erl) ||
                    (seg == SEG_KMAP_LO) || (seg == SEG_KMAP_HI);

  always_comb begin
    case (seg)
      SEG_KDIRECT:   fixed_pa = va - KDIRECT_BASE;
      SEG_KUNCACHED: fixed_pa = va - KUNCACHED_BASE;
      default:       fixed_pa = va;
    endcase
  end
endmodule

// File: rtl/vsm_tlb_check.sv
module vsm_tlb_check
  import vsm_pkg::*;
(
  input  logic              is_write,
  input  logic              hit,
  input  logic              ent_valid,
  input  logic              ent_dirty,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic              refill
);
  always_comb begin
    fault  = 1'b0;
    code   = EXC_NONE;
    refill = 1'b0;
    if (!hit) begin
      fault  = 1'b1;
      code   = is_write ? EXC_TLBS : EXC_TLBL;
      refill = 1'b1;
    end else if (!ent_valid) begin
      fault  = 1'b1;
      code   = is_write ? EXC_TLBS : EXC_TLBL;
    end else if (is_write && !ent_dirty) begin
      fault  = 1'b1;
      code   = EXC_MOD;
    end
  end
endmodule

// File: rtl/vsm_fault_regs.sv
module vsm_fault_regs
  import vsm_pkg::*;
#(
  parameter logic [VA_W-1:0] CTX_RST = 32'h0,
  parameter logic [VA_W-1:0] EHI_RST = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] badvaddr,
  output logic [VA_W-1:0] context_q,
  output logic [VA_W-1:0] entryhi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      badvaddr  <= '0;
      context_q <= CTX_RST;
      entryhi   <= EHI_RST;
    end else if (capture) begin
      badvaddr  <= va;
      context_q <= {va[VA_W-1:OFF_W], context_q[OFF_W-1:0]};
      entryhi   <= {va[VA_W-1:OFF_W], entryhi[OFF_W-1:0]};
    end
  end
endmodule

// File: rtl/vseg_mapper.sv
module vseg_mapper
  import vsm_pkg::*;
#(
  parameter logic [31:0] CTX_RST = 32'h0000_0ABC,
  parameter logic [31:0] EHI_RST = 32'h0000_0055
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        user_mode,
  input  logic        err_level,
  input  logic        tlb_hit,
  input  logic        tlb_valid,
  input  logic        tlb_dirty,
  input  logic [19:0] tlb_pfn,
  output logic        tlb_lookup,
  output logic        resp_valid,
  output logic [31:0] phys_addr,
  output logic        perm_rd,
  output logic        perm_wr,
  output logic        fault,
  output logic [4:0]  exc_code,
  output logic        exc_refill,
  output logic [31:0] rb_badvaddr,
  output logic [31:0] rb_context,
  output logic [31:0] rb_entryhi
);
  seg_e              seg;
  logic              mapped, addr_err;
  logic [VA_W-1:0]   fixed_pa;
  logic              t_fault, t_refill;
  logic [CODE_W-1:0] t_code;
  xlate_t            nxt, cur;

  vsm_seg_decode u_dec (
    .va(req_addr), .user(user_mode), .erl(err_level),
    .seg(seg), .mapped(mapped), .addr_err(addr_err), .fixed_pa(fixed_pa)
  );

  vsm_tlb_check u_chk_tlb (
    .is_write(req_write), .hit(tlb_hit), .ent_valid(tlb_valid),
    .ent_dirty(tlb_dirty), .fault(t_fault), .code(t_code), .refill(t_refill)
  );

  assign tlb_lookup = req_valid && mapped && !addr_err;

  always_comb begin
    nxt       = '0;
    nxt.valid = req_valid;
    if (req_valid) begin
      if (addr_err) begin
        nxt.fault = 1'b1;
        nxt.code  = req_write ? EXC_ADES : EXC_ADEL;
      end else if (mapped) begin
        if (t_fault) begin
          nxt.fault  = 1'b1;
          nxt.code   = t_code;
          nxt.refill = t_refill;
        end else begin
          nxt.pa = {tlb_pfn, req_addr[OFF_W-1:0]};
          nxt.rd = 1'b1;
          nxt.wr = tlb_dirty;
        end
      end else begin
        nxt.pa = fixed_pa;
        nxt.rd = 1'b1;
        nxt.wr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  vsm_fault_regs #(.CTX_RST(CTX_RST), .EHI_RST(EHI_RST)) u_regs (
    .clk(clk), .rst(rst), .capture(nxt.fault), .va(req_addr),
    .badvaddr(rb_badvaddr), .context_q(rb_context), .entryhi(rb_entryhi)
  );

  assign resp_valid = cur.valid;
  assign phys_addr  = cur.pa;
  assign perm_rd    = cur.rd;
  assign perm_wr    = cur.wr;
  assign fault      = cur.fault;
  assign exc_code   = cur.code;
  assign exc_refill = cur.refill;
endmodule

// File: rtl/vseg_mapper_chk.sv
module vseg_mapper_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic        user_mode,
  input logic        err_level,
  input logic        tlb_hit,
  input logic        tlb_lookup,
  input logic        resp_valid,
  input logic [31:0] phys_addr,
  input logic        perm_rd,
  input logic        perm_wr,
  input logic        fault,
  input logic [4:0]  exc_code,
  input logic        exc_refill,
  input logic [31:0] rb_badvaddr
);
  p_user_kernel_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && user_mode && req_addr[31]) |=>
      (fault && exc_code == ($past(req_write) ? 5'd5 : 5'd4) && !perm_rd && !perm_wr));

  p_direct_xlate_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !user_mode && req_addr[31:29] == 3'b100) |=>
      (!fault && phys_addr == $past(req_addr) - 32'h8000_0000));

  p_miss_refill_r6: assert property (@(posedge clk) disable iff (rst)
    (tlb_lookup && !tlb_hit) |=> (fault && exc_refill));

  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!fault || rb_badvaddr == $past(req_addr)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !fault && $stable(rb_badvaddr)));
endmodule

bind vseg_mapper vseg_mapper_chk u_chk (.*);

// File: tb/vseg_mapper_bench.sv
module vseg_mapper_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, user_mode, err_level;
  logic [31:0] req_addr;
  logic        tlb_hit, tlb_valid, tlb_dirty;
  logic [19:0] tlb_pfn;
  logic        tlb_lookup, resp_valid, perm_rd, perm_wr, fault, exc_refill;
  logic [31:0] phys_addr, rb_badvaddr, rb_context, rb_entryhi;
  logic [4:0]  exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_bad, m_ctx, m_ehi;

  always #10 clk = ~clk;

  vseg_mapper u_vseg_mapper (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag, bit v, logic [31:0] a, bit w, bit u, bit e,
                       bit h, bit vl, bit d, logic [19:0] pfn);
    bit          e_look, e_flt, e_ref, e_rd, e_wr;
    logic [4:0]  e_code;
    logic [31:0] e_pa;
    bit          mapd;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w; user_mode = u; err_level = e;
    tlb_hit = h; tlb_valid = vl; tlb_dirty = d; tlb_pfn = pfn;
    e_look = 0; e_flt = 0; e_ref = 0; e_rd = 0; e_wr = 0; e_code = 0; e_pa = 0;
    if (v) begin
      mapd = 0;
      if (u && a >= 32'h8000_0000) begin
        e_flt = 1; e_code = w ? 5'd5 : 5'd4;
      end else if (a < 32'h8000_0000 && e) begin
        e_pa = a; e_rd = 1; e_wr = 1;
      end else if (a >= 32'h8000_0000 && a < 32'hA000_0000) begin
        e_pa = a - 32'h8000_0000; e_rd = 1; e_wr = 1;
      end else if (a >= 32'hA000_0000 && a < 32'hC000_0000) begin
        e_pa = a - 32'hA000_0000; e_rd = 1; e_wr = 1;
      end else mapd = 1;
      if (mapd) begin
        e_look = 1;
        if (!h)               begin e_flt = 1; e_ref = 1; e_code = w ? 5'd3 : 5'd2; end
        else if (!vl)         begin e_flt = 1; e_code = w ? 5'd3 : 5'd2; end
        else if (w && !d)     begin e_flt = 1; e_code = 5'd1; end
        else begin e_pa = {pfn, a[11:0]}; e_rd = 1; e_wr = d; end
      end
    end
    #1;
    chk(tag, "tlb_lookup", 32'(tlb_lookup), 32'(e_look));
    if (e_flt) begin
      m_bad = a;
      m_ctx = {a[31:12], m_ctx[11:0]};
      m_ehi = {a[31:12], m_ehi[11:0]};
    end
    @(posedge clk); #1;
    chk(tag, "resp_valid", 32'(resp_valid), 32'(v));
    chk(tag, "fault", 32'(fault), 32'(e_flt));
    chk(tag, "exc_code", 32'(exc_code), 32'(e_code));
    chk(tag, "exc_refill", 32'(exc_refill), 32'(e_ref));
    chk(tag, "phys_addr", phys_addr, e_pa);
    chk(tag, "perm", 32'({perm_rd, perm_wr}), 32'({e_rd, e_wr}));
    chk(tag, "badvaddr", rb_badvaddr, m_bad);
    chk(tag, "context", rb_context, m_ctx);
    chk(tag, "entryhi", rb_entryhi, m_ehi);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_addr = 0; req_write = 0; user_mode = 0;
    err_level = 0; tlb_hit = 0; tlb_valid = 0; tlb_dirty = 0; tlb_pfn = 0;
    m_bad = 0; m_ctx = 32'h0000_0ABC; m_ehi = 32'h0000_0055;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11", "resp_valid", 32'(resp_valid), 0);
    chk("R11", "fault", 32'(fault), 0);
    chk("R11", "badvaddr", rb_badvaddr, 0);
    chk("R11", "context", rb_context, 32'h0000_0ABC);
    chk("R11", "entryhi", rb_entryhi, 32'h0000_0055);
    @(negedge clk); rst = 0;

    apply("R10", 0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R3",  1, 32'h8123_4567, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R3",  1, 32'h8000_0000, 1, 0, 0, 0, 0, 0, 20'h0);
    apply("R3",  1, 32'h9FFF_FFFF, 0, 0, 1, 0, 0, 0, 20'h0);
    apply("R4",  1, 32'hA000_0000, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R4",  1, 32'hBFFF_FFFC, 1, 0, 0, 0, 0, 0, 20'h0);
    apply("R2",  1, 32'h7FFF_FFFF, 1, 0, 1, 0, 0, 0, 20'h0);
    apply("R2",  1, 32'h0000_1000, 0, 1, 1, 0, 0, 0, 20'h0);
    apply("R1",  1, 32'h8000_0000, 0, 1, 1, 1, 1, 1, 20'h0);
    apply("R1",  1, 32'hFFFF_F123, 1, 1, 0, 1, 1, 1, 20'h0);
    apply("R10", 0, 32'hDEAD_B000, 1, 0, 0, 0, 0, 0, 20'h0);
    apply("R5",  1, 32'h0040_0ABC, 0, 1, 0, 1, 1, 0, 20'h12345);
    apply("R5",  1, 32'hC000_0010, 1, 0, 0, 1, 1, 1, 20'hFEDCB);
    apply("R5",  1, 32'hE000_0FFF, 0, 0, 0, 1, 1, 1, 20'h00001);
    apply("R8",  1, 32'h0040_2004, 1, 1, 0, 1, 1, 0, 20'h12345);
    apply("R6",  1, 32'h7FFF_F000, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R6",  1, 32'hC000_0000, 1, 0, 0, 0, 1, 1, 20'h0);
    apply("R7",  1, 32'hE123_4567, 0, 0, 0, 1, 0, 1, 20'h0);
    apply("R7",  1, 32'h0000_3000, 1, 1, 0, 1, 0, 0, 20'h0);
    apply("R9",  1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R10", 1, 32'h8765_4321, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R10", 0, 32'h0, 0, 0, 0, 0, 0, 0, 20'h0);
    apply("R9",  1, 32'h1357_9BDF, 1, 0, 0, 1, 1, 0, 20'hAAAAA);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule